// File: doc/BRIEF.md
# Codec input frame slot assembler for a serial audio link

The block builds the serial frame that an audio codec returns to its link controller once per frame period. From a register read result, a pair of ADC samples, the ADC power and rate state and a small slot-assignment code, it decides which slots of the frame carry data. It then sets the per-slot valid tags and the slot-request flags, forces every unused or invalid slot to zeros, and shifts the frame out on one serial data line, one bit per bit clock.

A frame is 256 bits long. It has a 16-bit tag slot followed by twelve 20-bit slots, and each slot goes out most significant bit first. A rising edge on the frame sync input captures the whole frame from the inputs on that bit-clock edge. Input changes after that edge wait for the next frame. Slot 1 carries the slot-request flags. Slot 2 carries the register read data. The left and right ADC samples go into one of four slot pairs, selected by the assignment code.

Top module: `acl_in_frame_asm`

## Requirements
- R1: On the rising bit-clock edge where `sync_in` is high and was low on the edge before, the frame is captured. From the following clock period onward, `sdata_out` presents frame bit 255 first and then each lower bit, one per clock. The frame is the tag slot in bits 255:240, followed by slot k (k = 1..12) in bits 239-20*(k-1) down to 220-20*(k-1).
- R2: Tag bit 15 equals `codec_rdy`. Tag bit 15-k is the valid flag of slot k. Slots 1 and 2 are flagged valid exactly when `stat_valid` is 1. Tag bits 2:0 are 0.
- R3: Slot 2 holds `stat_data` in its bits 19:4, with bits 3:0 at zero. When `stat_valid` is 0, all 20 bits of slot 2 are zero.
- R4: `pair_sel` picks the ADC slots as a (left, right) pair: code 0 gives (3, 4), code 1 gives (6, 9), code 2 gives (7, 8) and code 3 gives (10, 11).
- R5: When `smp_strobe` and `adc_pwr_ok` are both 1, the left slot carries `smp_left` and the right slot carries `smp_right`, all 20 bits, and both tag bits are 1. Otherwise both slots are zero and both tags are 0.
- R6: Slot 5, and every slot from 3 to 12 that is not in the selected ADC pair, is all zeros with its tag bit at 0.
- R7: When `var_rate` is 0, all of slot 1 is zero, so no slot is requested.
- R8: When `adc_pwr_ok` is 0, all of slot 1 is zero.
- R9: The request flag for slot n (n = 3..12) is bit 14-n of slot 1. It is 1 only for the two selected ADC slots, and only when `var_rate`, `adc_pwr_ok` and `rate_off48` are all 1 and `smp_strobe` is 0. All other bits of slot 1 are 0.
- R10: Input changes made after the capture edge do not alter the frame being shifted out.
- R11: While reset is asserted and after it, until the first capture, `sdata_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Frame sync; its rising edge captures a new frame |
| codec_rdy | input | 1 | Codec ready flag placed in tag bit 15 |
| stat_valid | input | 1 | Register read result is valid this frame |
| stat_data | input | 16 | Register read result |
| smp_strobe | input | 1 | A new ADC sample pair is present this frame |
| smp_left | input | 20 | Left ADC sample |
| smp_right | input | 20 | Right ADC sample |
| adc_pwr_ok | input | 1 | ADC powered and ready |
| var_rate | input | 1 | Variable-rate mode enabled |
| rate_off48 | input | 1 | ADC rate differs from 48 kHz |
| pair_sel | input | 2 | ADC slot pair selection code |
| sdata_out | output | 1 | Serial frame data, most significant bit first |

## Verification
The bench runs every combination of the four pair codes with the variable-rate, power-ready, non-48 kHz, sample-strobe and read-valid inputs. This shows that slot requests appear only under the one enabling combination, and that fixed-rate mode or power-down each suppress them on their own. The sample and read data change with every frame, and the left and right samples differ from each other. This exposes a swapped channel, a misplaced pair or stale data. Every slot outside the selected pair is checked to be empty. A separate frame changes all inputs after the capture edge, to show that the frame already being shifted out is not affected.

// File: rtl/acl_frame_pkg.sv
package acl_frame_pkg;

   typedef enum logic [1:0] {
      PAIR_S3_S4   = 2'd0,
      PAIR_S6_S9   = 2'd1,
      PAIR_S7_S8   = 2'd2,
      PAIR_S10_S11 = 2'd3
   } pair_sel_e;

   function automatic int left_slot(pair_sel_e p);
      case (p)
         PAIR_S3_S4:   return 3;
         PAIR_S6_S9:   return 6;
         PAIR_S7_S8:   return 7;
         default:      return 10;
      endcase
   endfunction

   function automatic int right_slot(pair_sel_e p);
      case (p)
         PAIR_S3_S4:   return 4;
         PAIR_S6_S9:   return 9;
         PAIR_S7_S8:   return 8;
         default:      return 11;
      endcase
   endfunction

endpackage

// File: rtl/acl_slot_map.sv
module acl_slot_map
   import acl_frame_pkg::*;
#(
   parameter int NUM_SLOTS = 12
) (
   input  pair_sel_e              sel,
   output logic [NUM_SLOTS:1]     left_mask,
   output logic [NUM_SLOTS:1]     right_mask
);

   always_comb begin
      for (int s = 1; s <= NUM_SLOTS; s++) begin
         left_mask[s]  = (s == left_slot(sel));
         right_mask[s] = (s == right_slot(sel));
      end
   end

endmodule

// File: rtl/acl_slot_builder.sv
module acl_slot_builder #(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int RD_W      = 16,
   parameter int SMP_W     = 20,
   parameter int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS
) (
   input  logic                   codec_rdy,
   input  logic                   stat_valid,
   input  logic [RD_W-1:0]        stat_data,
   input  logic                   smp_strobe,
   input  logic [SMP_W-1:0]       smp_left,
   input  logic [SMP_W-1:0]       smp_right,
   input  logic                   adc_pwr_ok,
   input  logic                   var_rate,
   input  logic                   rate_off48,
   input  logic [NUM_SLOTS:1]     left_mask,
   input  logic [NUM_SLOTS:1]     right_mask,
   output logic [FRAME_W-1:0]     frame
);

   localparam int BODY_TOP = FRAME_W - TAG_W - 1;

   logic                req_now;
   logic                adc_take;
   logic [SLOT_W-1:0]   req_word;
   logic [SLOT_W-1:0]   slot_dat [1:NUM_SLOTS];
   logic                slot_tag [1:NUM_SLOTS];

   // request only when rate is variable, ADC ready, not 48 kHz, no sample due
   assign req_now  = var_rate & adc_pwr_ok & rate_off48 & ~smp_strobe;
   assign adc_take = smp_strobe & adc_pwr_ok;

   always_comb begin
      req_word = '0;
      for (int n = 3; n <= NUM_SLOTS; n++)
         req_word[SLOT_W-6-n] = req_now & (left_mask[n] | right_mask[n]);
   end

   for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
      if (s == 1) begin : g_req
         assign slot_tag[s] = stat_valid;
         assign slot_dat[s] = req_word;
      end else if (s == 2) begin : g_stat
         assign slot_tag[s] = stat_valid;
         assign slot_dat[s] = stat_valid ? (SLOT_W'(stat_data) << (SLOT_W - RD_W)) : '0;
      end else begin : g_adc
         logic mine;
         assign mine        = left_mask[s] | right_mask[s];
         assign slot_tag[s] = mine & adc_take;
         assign slot_dat[s] = !(mine & adc_take) ? '0 :
                              left_mask[s] ? (SLOT_W'(smp_left)  << (SLOT_W - SMP_W)) :
                                             (SLOT_W'(smp_right) << (SLOT_W - SMP_W));
      end
   end

   always_comb begin
      frame            = '0;
      frame[FRAME_W-1] = codec_rdy;
      for (int s = 1; s <= NUM_SLOTS; s++) begin
         frame[FRAME_W-1-s]                          = slot_tag[s];
         frame[BODY_TOP - SLOT_W*(s-1) -: SLOT_W]    = slot_dat[s];
      end
   end

endmodule

// File: rtl/acl_frame_shifter.sv
module acl_frame_shifter #(
   parameter int FRAME_W = 256
) (
   input  logic                bit_clk,
   input  logic                rst_n,
   input  logic                sync_in,
   input  logic [FRAME_W-1:0]  frame_in,
   output logic                sdata_out
);

   logic                sync_q;
   logic                load;
   logic [FRAME_W-1:0]  shreg;

   assign load      = sync_in & ~sync_q;
   assign sdata_out = shreg[FRAME_W-1];

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         shreg  <= '0;
      end else begin
         sync_q <= sync_in;
         if (load) shreg <= frame_in;
         else      shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
   end

   assert_capture_msb_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
      load |=> sdata_out == $past(frame_in[FRAME_W-1]));

   assert_hold_frame_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !load |=> sdata_out == $past(shreg[FRAME_W-2]));

endmodule

// File: rtl/acl_in_frame_asm.sv
module acl_in_frame_asm
   import acl_frame_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int RD_W      = 16,
   parameter int SMP_W     = 20
) (
   input  logic               bit_clk,
   input  logic               rst_n,
   input  logic               sync_in,
   input  logic               codec_rdy,
   input  logic               stat_valid,
   input  logic [RD_W-1:0]    stat_data,
   input  logic               smp_strobe,
   input  logic [SMP_W-1:0]   smp_left,
   input  logic [SMP_W-1:0]   smp_right,
   input  logic               adc_pwr_ok,
   input  logic               var_rate,
   input  logic               rate_off48,
   input  logic [1:0]         pair_sel,
   output logic               sdata_out
);

   localparam int FRAME_W  = TAG_W + SLOT_W * NUM_SLOTS;
   localparam int BODY_TOP = FRAME_W - TAG_W - 1;

   if (NUM_SLOTS < 11)            begin : g_bad_slots $error("NUM_SLOTS must reach slot 11"); end
   if (TAG_W < NUM_SLOTS + 1)     begin : g_bad_tag   $error("TAG_W too small for slot tags"); end
   if (SLOT_W < NUM_SLOTS + 6)    begin : g_bad_req   $error("SLOT_W too small for request flags"); end
   if (SLOT_W < RD_W)             begin : g_bad_rd    $error("RD_W exceeds SLOT_W"); end
   if (SLOT_W < SMP_W)            begin : g_bad_smp   $error("SMP_W exceeds SLOT_W"); end

   logic [NUM_SLOTS:1]  left_mask;
   logic [NUM_SLOTS:1]  right_mask;
   logic [FRAME_W-1:0]  frame_w;

   acl_slot_map #(.NUM_SLOTS(NUM_SLOTS)) i_map (
      .sel        (pair_sel_e'(pair_sel)),
      .left_mask  (left_mask),
      .right_mask (right_mask)
   );

   acl_slot_builder #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
      .RD_W(RD_W), .SMP_W(SMP_W), .FRAME_W(FRAME_W)
   ) i_builder (
      .codec_rdy  (codec_rdy),
      .stat_valid (stat_valid),
      .stat_data  (stat_data),
      .smp_strobe (smp_strobe),
      .smp_left   (smp_left),
      .smp_right  (smp_right),
      .adc_pwr_ok (adc_pwr_ok),
      .var_rate   (var_rate),
      .rate_off48 (rate_off48),
      .left_mask  (left_mask),
      .right_mask (right_mask),
      .frame      (frame_w)
   );

   acl_frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
      .bit_clk   (bit_clk),
      .rst_n     (rst_n),
      .sync_in   (sync_in),
      .frame_in  (frame_w),
      .sdata_out (sdata_out)
   );

   assert_fixed_rate_noreq_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !var_rate |-> frame_w[BODY_TOP -: SLOT_W] == '0);

   assert_powerdown_noreq_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !adc_pwr_ok |-> frame_w[BODY_TOP -: SLOT_W] == '0);

   assert_stat_stuffed_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !stat_valid |-> (frame_w[BODY_TOP - SLOT_W -: SLOT_W] == '0) && !frame_w[FRAME_W-3]);

   assert_slot5_empty_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
      frame_w[BODY_TOP - SLOT_W*4 -: SLOT_W] == '0 && !frame_w[FRAME_W-6]);

   assert_pair_only_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $countones(frame_w[FRAME_W-4 -: NUM_SLOTS-2]) <= 2);

   assert_one_slot_each_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $countones(left_mask) == 1 && $countones(right_mask) == 1 && (left_mask & right_mask) == '0);

endmodule

// File: tb/test_acl_in_frame_asm.sv
module test_acl_in_frame_asm;

   logic         bit_clk = 1'b0;
   logic         rst_n;
   logic         sync_in;
   logic         codec_rdy, stat_valid, smp_strobe, adc_pwr_ok, var_rate, rate_off48;
   logic [15:0]  stat_data;
   logic [19:0]  smp_left, smp_right;
   logic [1:0]   pair_sel;
   logic         sdata_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 bit_clk = ~bit_clk;   // 50 MHz

   acl_in_frame_asm i_acl_in_frame_asm (
      .bit_clk(bit_clk), .rst_n(rst_n), .sync_in(sync_in), .codec_rdy(codec_rdy),
      .stat_valid(stat_valid), .stat_data(stat_data), .smp_strobe(smp_strobe),
      .smp_left(smp_left), .smp_right(smp_right), .adc_pwr_ok(adc_pwr_ok),
      .var_rate(var_rate), .rate_off48(rate_off48), .pair_sel(pair_sel),
      .sdata_out(sdata_out)
   );

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] slot_of(input logic [255:0] f, input int k);
      return f[239 - 20*(k-1) -: 20];
   endfunction

   function automatic int lslot(input logic [1:0] s);
      return (s == 0) ? 3 : (s == 1) ? 6 : (s == 2) ? 7 : 10;
   endfunction

   function automatic int rslot(input logic [1:0] s);
      return (s == 0) ? 4 : (s == 1) ? 9 : (s == 2) ? 8 : 11;
   endfunction

   function automatic logic [255:0] expect_frame();
      logic [255:0] f;
      int li, ri;
      logic take, req;
      li   = lslot(pair_sel);
      ri   = rslot(pair_sel);
      take = smp_strobe & adc_pwr_ok;
      req  = var_rate & adc_pwr_ok & rate_off48 & ~smp_strobe;
      f = '0;
      f[255] = codec_rdy;
      f[254] = stat_valid;
      f[253] = stat_valid;
      f[220 + 14 - li] = req;
      f[220 + 14 - ri] = req;
      if (stat_valid) f[219:204] = stat_data;
      if (take) begin
         f[255 - li] = 1'b1;
         f[255 - ri] = 1'b1;
         f[239 - 20*(li-1) -: 20] = smp_left;
         f[239 - 20*(ri-1) -: 20] = smp_right;
      end
      return f;
   endfunction

   task automatic set_cfg(input int c);
      pair_sel   = c[1:0];
      var_rate   = c[2];
      adc_pwr_ok = c[3];
      rate_off48 = c[4];
      smp_strobe = c[5];
      stat_valid = c[6];
      codec_rdy  = c[0] ^ c[3];
      stat_data  = 16'hA5C3 ^ 16'(c * 16'h0101);
      smp_left   = 20'h80001 + 20'(c * 20'h01357);
      smp_right  = 20'h7FFFE ^ 20'(c << 7);
   endtask

   task automatic run_frame(output logic [255:0] f, input int change_to);
      @(negedge bit_clk) sync_in = 1'b1;
      @(posedge bit_clk);
      for (int i = 0; i < 256; i++) begin
         @(negedge bit_clk);
         f[255 - i] = sdata_out;
         if (i == 0) sync_in = 1'b0;
         if (i == 3 && change_to >= 0) set_cfg(change_to);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [255:0] act, exp;
      rst_n = 1'b0;
      sync_in = 1'b0;
      set_cfg(127);
      repeat (3) @(posedge bit_clk);
      #1 chk("R11 reset output", 256'(sdata_out), 256'(0));
      @(negedge bit_clk) rst_n = 1'b1;
      repeat (4) begin
         @(negedge bit_clk);
         chk("R11 idle output after reset", 256'(sdata_out), 256'(0));
      end

      for (int c = 0; c < 128; c++) begin
         int li, ri;
         set_cfg(c);
         exp = expect_frame();
         li  = lslot(pair_sel);
         ri  = rslot(pair_sel);
         run_frame(act, -1);
         chk("R1 whole frame", act, exp);
         chk("R2 tag slot", 256'(act[255:240]), 256'(exp[255:240]));
         chk("R3 status slot", 256'(slot_of(act, 2)), 256'(slot_of(exp, 2)));
         chk("R4 R5 left ADC slot", 256'(slot_of(act, li)), 256'(slot_of(exp, li)));
         chk("R4 R5 right ADC slot", 256'(slot_of(act, ri)), 256'(slot_of(exp, ri)));
         if (!var_rate)
            chk("R7 fixed rate slot1", 256'(slot_of(act, 1)), 256'(0));
         else if (!adc_pwr_ok)
            chk("R8 powered down slot1", 256'(slot_of(act, 1)), 256'(0));
         else
            chk("R9 request flags", 256'(slot_of(act, 1)), 256'(slot_of(exp, 1)));
         chk("R6 slot5 empty", 256'({act[250], slot_of(act, 5)}), 256'(0));
         for (int k = 3; k <= 12; k++) begin
            if (k != li && k != ri)
               chk("R6 unassigned slot empty", 256'({act[255-k], slot_of(act, k)}), 256'(0));
         end
      end

      // mid-frame changes must not alter the frame in flight
      set_cfg(124);
      exp = expect_frame();
      run_frame(act, 43);
      chk("R10 frame latched at sync", act, exp);
      exp = expect_frame();
      run_frame(act, -1);
      chk("R10 next frame uses new inputs", act, exp);
      repeat (3) begin
         @(negedge bit_clk);
         chk("R1 zeros after frame end", 256'(sdata_out), 256'(0));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule